// File: doc/BRIEF.md
# Two-Channel Bus Cycle Break Unit

This unit watches every cycle on a processor's bus and raises a break request when a cycle meets programmed conditions. Two channels, A and B, each hold a compare address with a bit mask and a cycle condition. The condition selects which master owns the bus, whether the cycle is an instruction fetch or a data access, its direction, and optionally its width. Channel B can also compare the bus data under a mask. A mode bit chooses between independent operation, where either channel fires alone, and an ordered mode, where channel B fires only after channel A has matched.

Matches are not delivered at once. A match becomes a pending break, which is handed to the core as a one-cycle request at the next instruction boundary that can accept an interrupt. A fetch condition can ask for the break before or after the fetched instruction runs. An after-execution break waits for one extra boundary, which is where that instruction completes. Data-access breaks are delivered at the nearest boundary. Software programs the unit through a plain write port. Exception entry is left to the core.

Top module: `brk_watch`

## Requirements
- R1: After reset every condition register is zero, the mode is independent and `brk_req` is low. A condition whose master, kind or direction field is 00 never matches, so no break occurs.
- R2: An address matches when every bit that is 0 in the mask equals the compare address. Mask 0x6 on 0x8010 matches 0x8010, 0x8012, 0x8014 and 0x8016, but not 0x8011 or 0x8018.
- R3: Condition layout: bits[1:0] master (bit0 CPU, bit1 other master), bits[3:2] kind (bit2 fetch, bit3 data), bits[5:4] direction (bit4 read, bit5 write), bits[7:6] size (00 any, 01 byte, 10 word, 11 long, compared with `bus_size` codes 0/1/2), bit8 after-execution. Every field must accept the cycle.
- R4: On data cycles, channel B also requires `bus_data` to equal the data register on every bit that is 0 in the data mask. On fetch cycles the data is ignored.
- R5: In independent mode (control bit0 = 0) either channel's match alone causes a break. When both match in one cycle, channel A's condition decides the timing.
- R6: In ordered mode (control bit0 = 1), only a channel B match that comes after an earlier channel A match causes a break. A and B matching in the same cycle only arms the unit.
- R7: The armed state clears when a break is delivered, when the control register is written, or when any of channel A's three registers is written.
- R8: A before-execution fetch match is delivered at the next open boundary with `brk_after` = 0.
- R9: An after-execution fetch match is held through the next boundary. It is delivered at the open boundary after that with `brk_after` = 1.
- R10: A data-access match is delivered at the next open boundary with `brk_after` = 1.
- R11: A boundary with `bnd_blocked` high delivers nothing. The pending break waits for the next open boundary.
- R12: `brk_req` is high for exactly the one cycle after the clock edge at which an open boundary met a pending break.
- R13: A match that arrives while a break is pending or held, or on the edge where one is delivered, is merged into that break. No second request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register index: 0 A addr, 1 A mask, 2 A cond, 3 B addr, 4 B mask, 5 B cond, 6 B data, 7 B data mask, 8 control |
| reg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_other | input | 1 | 1 when a non-CPU master owns the cycle |
| bus_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | 0 byte, 1 word, 2 long |
| bnd | input | 1 | Instruction boundary strobe |
| bnd_blocked | input | 1 | The boundary cannot accept an interrupt |
| brk_req | output | 1 | One-cycle break request |
| brk_after | output | 1 | Tag: 1 after-execution or data break, 0 before-execution |

## Verification
Two events can land on the same clock edge: a fresh match and the delivery of an earlier pending break. In independent mode, channels A and B can also match the same cycle. The bench drives a matching fetch in the very cycle it raises an open boundary. The scoreboard then expects exactly one request with the older break's tag and nothing at the following boundaries. For the two-channel collision, channel A is set to before-execution and channel B to after-execution on one address. The bench expects a tag-0 request at the next boundary and silence after. In ordered mode, an A+B cycle must produce nothing until a later lone B match.

// File: rtl/brk_watch.sv
module brk_watch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_other,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic          bnd,
  input  logic          bnd_blocked,
  output logic          brk_req,
  output logic          brk_after
);
  localparam int CW = 9;

  logic [AW-1:0] a_addr, a_mask, b_addr, b_mask;
  logic [DW-1:0] b_data, b_dmask;
  logic [CW-1:0] a_cond, b_cond;
  logic          seq, armed;
  logic          pend, pend_tag, held;

  function automatic logic cond_ok(input logic [CW-1:0] c, input logic oth,
                                   input logic fe, input logic wr, input logic [1:0] sz);
    logic m, k, d, s;
    m = oth ? c[1] : c[0];
    k = fe  ? c[2] : c[3];
    d = wr  ? c[5] : c[4];
    s = (c[7:6] == 2'b00) || (c[7:6] == sz + 2'd1);
    return m && k && d && s;
  endfunction

  wire hit_a = bus_valid && cond_ok(a_cond, bus_other, bus_fetch, bus_write, bus_size)
               && (((bus_addr ^ a_addr) & ~a_mask) == '0);
  wire hit_b = bus_valid && cond_ok(b_cond, bus_other, bus_fetch, bus_write, bus_size)
               && (((bus_addr ^ b_addr) & ~b_mask) == '0)
               && (bus_fetch || (((bus_data ^ b_data) & ~b_dmask) == '0));

  wire              trig    = seq ? (hit_b && armed) : (hit_a || hit_b);
  wire [CW-1:0]     tcond   = (seq || !hit_a) ? b_cond : a_cond;
  wire              late    = bus_fetch && tcond[8];
  wire              new_tag = !bus_fetch || tcond[8];
  wire              deliver = bnd && !bnd_blocked && pend;
  wire              free    = !pend && !held;
  wire              a_wr    = reg_we && (reg_sel <= 4'd2 || reg_sel == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr <= '0; a_mask <= '0; a_cond <= '0;
      b_addr <= '0; b_mask <= '0; b_cond <= '0;
      b_data <= '0; b_dmask <= '0; seq <= 1'b0;
    end else if (reg_we) begin
      case (reg_sel)
        4'd0: a_addr  <= reg_wdata[AW-1:0];
        4'd1: a_mask  <= reg_wdata[AW-1:0];
        4'd2: a_cond  <= reg_wdata[CW-1:0];
        4'd3: b_addr  <= reg_wdata[AW-1:0];
        4'd4: b_mask  <= reg_wdata[AW-1:0];
        4'd5: b_cond  <= reg_wdata[CW-1:0];
        4'd6: b_data  <= reg_wdata[DW-1:0];
        4'd7: b_dmask <= reg_wdata[DW-1:0];
        4'd8: seq     <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (a_wr || deliver) armed <= 1'b0;
    else if (seq && hit_a) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_tag <= 1'b0; held <= 1'b0;
      brk_req <= 1'b0; brk_after <= 1'b0;
    end else begin
      brk_req <= deliver;
      if (deliver) brk_after <= pend_tag;
      if (held && bnd) begin
        held <= 1'b0; pend <= 1'b1; pend_tag <= 1'b1;
      end else if (deliver) begin
        pend <= 1'b0;
      end else if (trig && free) begin
        if (late) held <= 1'b1;
        else begin pend <= 1'b1; pend_tag <= new_tag; end
      end
    end
  end

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);
  assert_open_bnd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bnd && !bnd_blocked));
  assert_merge_R13: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (!pend && !held));
  assert_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && bnd) |=> (pend && pend_tag && !brk_req));
endmodule

// File: tb/sim_brk_watch.sv
module sim_brk_watch;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [3:0] reg_sel = 0; logic [31:0] reg_wdata = 0;
  logic bus_valid = 0; logic [31:0] bus_addr = 0, bus_data = 0;
  logic bus_other = 0, bus_fetch = 0, bus_write = 0; logic [1:0] bus_size = 0;
  logic bnd = 0, bnd_blocked = 0;
  logic brk_req, brk_after;

  int compared = 0, mismatched = 0, cyc = 0;
  int q_cyc[$]; bit q_tag[$]; string q_req[$];

  brk_watch u0 (.clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .bus_valid, .bus_addr,
                .bus_data, .bus_other, .bus_fetch, .bus_write, .bus_size, .bnd,
                .bnd_blocked, .brk_req, .brk_after);

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && brk_req) begin
    compared++;
    if (q_cyc.size() == 0) begin
      mismatched++; $display("FAIL unexpected break: actual req=1 expected none (cyc %0d)", cyc);
    end else begin
      int ec; bit et; string er;
      ec = q_cyc.pop_front(); et = q_tag.pop_front(); er = q_req.pop_front();
      if (ec != cyc || et != brk_after) begin
        mismatched++;
        $display("FAIL %s: actual cyc=%0d tag=%0b expected cyc=%0d tag=%0b", er, cyc, brk_after, ec, et);
      end
    end
  end

  task automatic wr(input int sel, input int val);
    reg_we = 1; reg_sel = sel[3:0]; reg_wdata = val;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic bus(input int a, input int d, input bit oth, input bit f, input bit w,
                     input int sz, input bit with_bnd = 0);
    bus_valid = 1; bus_addr = a; bus_data = d; bus_other = oth;
    bus_fetch = f; bus_write = w; bus_size = sz[1:0]; bnd = with_bnd;
    @(negedge clk); bus_valid = 0; bnd = 0;
  endtask

  task automatic boundary(input bit blocked, input bit expect_brk, input bit tag, input string r);
    bnd = 1; bnd_blocked = blocked;
    if (expect_brk) begin q_cyc.push_back(cyc + 1); q_tag.push_back(tag); q_req.push_back(r); end
    @(negedge clk); bnd = 0; bnd_blocked = 0;
  endtask

  task automatic quiet(input string r);
    boundary(0, 0, 0, r); boundary(0, 0, 0, r); @(negedge clk);
    compared++;
    if (q_cyc.size() != 0) begin
      mismatched++; $display("FAIL %s: actual %0d breaks outstanding expected 0", r, q_cyc.size());
      q_cyc.delete(); q_tag.delete(); q_req.delete();
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (brk_req !== 1'b0) begin mismatched++; $display("FAIL R1: actual req=%b expected 0", brk_req); end
    rst_n = 1; @(negedge clk);
    bus(0, 0, 0, 1, 0, 1); boundary(0, 0, 0, "R1"); quiet("R1");

    wr(0, 'h8010); wr(1, 'h6); wr(2, 'h15);
    for (int i = 0; i < 4; i++) begin
      bus('h8010 + 2*i, 0, 0, 1, 0, 1); boundary(0, 1, 0, "R2 R8 masked fetch");
    end
    bus('h8011, 0, 0, 1, 0, 1); bus('h8018, 0, 0, 1, 0, 1); quiet("R2 outside mask");

    wr(2, 'h95);
    bus('h8010, 0, 0, 1, 0, 0); bus('h8010, 0, 1, 1, 0, 1); bus('h8010, 0, 0, 1, 1, 1);
    bus('h8010, 0, 0, 0, 0, 1); quiet("R3 rejected cycles");
    bus('h8010, 0, 0, 1, 0, 1); boundary(0, 1, 0, "R3 word fetch");

    wr(2, 'h115);
    bus('h8012, 0, 0, 1, 0, 2); boundary(0, 0, 0, "R9"); boundary(0, 1, 1, "R9 after exec");
    quiet("R9");

    wr(2, 0); wr(3, 'h100); wr(4, 0); wr(5, 'h29); wr(6, 0); wr(7, 0);
    bus('h100, 0, 0, 0, 1, 2); boundary(0, 1, 1, "R10 data break");
    bus('h100, 5, 0, 0, 1, 2); quiet("R4 data mismatch");
    wr(7, 'hF);
    bus('h100, 5, 0, 0, 1, 2); boundary(0, 1, 1, "R4 masked data");
    wr(7, 0); wr(5, 'h15);
    bus('h100, 'h1234, 0, 1, 0, 1); boundary(0, 1, 0, "R4 fetch ignores data");

    bus('h100, 0, 0, 1, 0, 1); boundary(1, 0, 0, "R11"); boundary(1, 0, 0, "R11");
    boundary(0, 1, 0, "R11 open boundary");

    bus('h100, 0, 0, 1, 0, 1); bus('h100, 0, 0, 1, 0, 1);
    boundary(0, 1, 0, "R13 merged"); quiet("R13");
    bus('h100, 0, 0, 1, 0, 1);
    q_cyc.push_back(cyc + 1); q_tag.push_back(0); q_req.push_back("R13 match on delivery");
    bus('h100, 0, 0, 1, 0, 1, 1); quiet("R13 dropped");

    wr(0, 'h100); wr(1, 0); wr(2, 'h15); wr(5, 'h115);
    bus('h100, 0, 0, 1, 0, 1); boundary(0, 1, 0, "R5 A wins"); quiet("R5");
    wr(2, 0);
    bus('h100, 0, 0, 1, 0, 1); boundary(0, 0, 0, "R5 B alone"); boundary(0, 1, 1, "R5 B alone");

    wr(0, 'h200); wr(2, 'h15); wr(5, 'h15); wr(8, 1);
    bus('h100, 0, 0, 1, 0, 1); quiet("R6 B without A");
    bus('h200, 0, 0, 1, 0, 1); bus('h100, 0, 0, 1, 0, 1); boundary(0, 1, 0, "R6 A then B");
    bus('h100, 0, 0, 1, 0, 1); quiet("R7 cleared by delivery");
    wr(0, 'h100);
    bus('h100, 0, 0, 1, 0, 1); quiet("R6 A+B same cycle");
    bus('h100, 0, 0, 1, 0, 1); boundary(0, 1, 0, "R6 B after A+B");
    wr(0, 'h200);
    bus('h200, 0, 0, 1, 0, 1); wr(1, 0); bus('h100, 0, 0, 1, 0, 1); quiet("R7 A reg write");
    bus('h200, 0, 0, 1, 0, 1); wr(8, 1); bus('h100, 0, 0, 1, 0, 1); quiet("R7 ctrl write");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule